// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block watches two independent memory ports that share one word array. Each port presents a word address, a pair of chip enables (one active-low, one active-high), a write strobe and per-byte enables. When both ports are selected on the same word, the block names a winner and pulls the active-low busy flag of the other port. It also suppresses that port's byte write strobes before they reach the array. The memory itself is not part of the block. It only consumes the gated per-byte write strobes that this block produces.

A mode input picks one of two roles. As the master, the block computes busy itself and drives it out. As a slave, it leaves its busy outputs inactive, and two external active-low busy inputs act only as write inhibits, one for each port. Everything is clocked on one clock. "Earlier" means the port that already held its selected address on the previous clock edge. A write that was blocked does not resume on its own. The port must drop its write strobe and raise it again.

Top module: `dp_busy_arb`

## Requirements
- R1: A port is selected only when its `*_ce0_n` input is 0 and its `*_ce1` input is 1 in the same cycle; any other combination deselects it.
- R2: A busy output goes low only while both ports are selected and `l_addr` equals `r_addr`; otherwise both busy outputs are 1.
- R3: The winner is chosen from chip enables and addresses alone; the write strobes and byte enables of either port do not change which side receives busy.
- R4: In master mode, when the ports match and exactly one of them was selected on the same address in the previous cycle, that port wins and the other port's busy output is 0 in the same cycle; the loser stays busy for as long as the match continues unchanged.
- R5: When both ports arrive on a matching address in the same cycle, the right port receives busy (`r_busy_out_n` = 0). The two busy outputs are never 0 together.
- R6: In master mode, a port whose busy output is 0 has all bits of its write strobe output (`l_wr` / `r_wr`) at 0, and the external busy inputs have no effect.
- R7: In slave mode (`master` = 0) both busy outputs stay 1 even on a match. A busy input at 0 forces that port's write strobe output to 0, and a busy input at 1 leaves writes unaffected.
- R8: Busy is released combinationally: in the first cycle in which the match ends, both busy outputs are 1 again.
- R9: Once a write has been blocked, that port's write strobe output stays 0 while its `*_we` remains 1, even after the block is lifted. It resumes only after `*_we` has been 0 for at least one cycle.
- R10: While `rst` is 1 both busy outputs are 1 and both write strobe outputs are 0. The first cycle after reset treats both ports as new arrivals.
- R11: Bit b of a port's write strobe output is 1 exactly when that port is selected, its `*_we` is 1, bit b of its byte enable is 1, and the port is neither blocked nor held off by R9. Bit 0 is the low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master | input | 1 | 1 = busy produced and driven out, 0 = busy inputs only inhibit writes |
| l_ce0_n | input | 1 | Left active-low chip enable |
| l_ce1 | input | 1 | Left active-high chip enable |
| l_we | input | 1 | Left write strobe, active high |
| l_be | input | BYTES | Left byte enables |
| l_addr | input | ADDR_W | Left word address |
| r_ce0_n | input | 1 | Right active-low chip enable |
| r_ce1 | input | 1 | Right active-high chip enable |
| r_we | input | 1 | Right write strobe, active high |
| r_be | input | BYTES | Right byte enables |
| r_addr | input | ADDR_W | Right word address |
| l_busy_in_n | input | 1 | Left external busy, active low, used in slave mode |
| r_busy_in_n | input | 1 | Right external busy, active low, used in slave mode |
| l_busy_out_n | output | 1 | Left busy flag, active low |
| r_busy_out_n | output | 1 | Right busy flag, active low |
| l_wr | output | BYTES | Gated per-byte write strobes, left port |
| r_wr | output | BYTES | Gated per-byte write strobes, right port |

## Verification
The busy outputs and the gated write strobes are combinational in the current inputs. They are due in the same cycle as the stimulus, and they are shaped by history registered on the preceding rising edge: which port held its address, who lost, and whether a write was held off. The bench therefore changes inputs on the falling edge and compares outputs one nanosecond later, before the next rising edge. Each vector thus sees exactly the history built by the rows before it. Arrival order (R4, R5) and the re-strobe rule (R9) are tested by sequences of consecutive vectors, not by single ones.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  typedef enum logic [1:0] {
    LOSE_NONE  = 2'b00,
    LOSE_LEFT  = 2'b01,
    LOSE_RIGHT = 2'b10
  } loser_e;

  // A port is live only with the low-true enable low and the high-true enable high.
  function automatic logic port_live(input logic ce_lo_n, input logic ce_hi);
    return !ce_lo_n && ce_hi;
  endfunction

  // Decide which side loses a collision from arrival history.
  function automatic loser_e pick_loser(input logic hit, input logic held_l,
                                        input logic held_r, input loser_e prior);
    loser_e res;
    if (!hit)                  res = LOSE_NONE;
    else if (held_l && held_r) res = (prior == LOSE_NONE) ? LOSE_RIGHT : prior;
    else if (held_l)           res = LOSE_RIGHT;
    else if (held_r)           res = LOSE_LEFT;
    else                       res = LOSE_RIGHT;   // same-cycle arrival: left favoured
    return res;
  endfunction

endpackage

// File: rtl/dpb_port_track.sv
module dpb_port_track #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel,
  output logic              held
);
  import dpb_pkg::*;

  logic              sel_q;
  logic [ADDR_W-1:0] addr_q;

  assign sel  = port_live(ce0_n, ce1);
  assign held = sel && sel_q && (addr_q == addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      sel_q  <= sel;
      addr_q <= addr;
    end
  end
endmodule

// File: rtl/dpb_arbiter.sv
module dpb_arbiter #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_l,
  input  logic              sel_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              held_l,
  input  logic              held_r,
  output logic              hit,
  output dpb_pkg::loser_e   loser
);
  import dpb_pkg::*;

  loser_e loser_q;

  assign hit   = sel_l && sel_r && (addr_l == addr_r);
  assign loser = pick_loser(hit, held_l, held_r, loser_q);

  always_ff @(posedge clk) begin
    if (rst) loser_q <= LOSE_NONE;
    else     loser_q <= loser;
  end
endmodule

// File: rtl/dpb_write_gate.sv
module dpb_write_gate #(
  parameter int BYTES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             we,
  input  logic [BYTES-1:0] be,
  input  logic             block,
  output logic [BYTES-1:0] wr,
  output logic             blocked
);
  logic hold_q;
  logic pass;

  assign blocked = !rst && sel && we && block;
  assign pass    = !rst && sel && we && !block && !hold_q;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign wr[b] = pass && be[b];
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= we && (blocked || hold_q);
  end
endmodule

// File: rtl/dp_busy_arb.sv
module dp_busy_arb #(
  parameter int ADDR_W = 15,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master,
  input  logic              l_ce0_n,
  input  logic              l_ce1,
  input  logic              l_we,
  input  logic [BYTES-1:0]  l_be,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce0_n,
  input  logic              r_ce1,
  input  logic              r_we,
  input  logic [BYTES-1:0]  r_be,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_out_n,
  output logic              r_busy_out_n,
  output logic [BYTES-1:0]  l_wr,
  output logic [BYTES-1:0]  r_wr
);
  import dpb_pkg::*;

  localparam int SIDES = 2;

  logic [SIDES-1:0]  ce0_n_v, ce1_v, we_v, sel_v, held_v;
  logic [SIDES-1:0]  bsy_in_n_v, busy_int_v, block_v, blocked_v;
  logic [ADDR_W-1:0] addr_v [SIDES];
  logic [BYTES-1:0]  be_v   [SIDES];
  logic [BYTES-1:0]  wr_v   [SIDES];

  // Named internal events for the checker.
  logic   hit;
  loser_e loser;
  logic   l_sel, r_sel, l_blocked, r_blocked;

  assign ce0_n_v    = {r_ce0_n, l_ce0_n};
  assign ce1_v      = {r_ce1, l_ce1};
  assign we_v       = {r_we, l_we};
  assign bsy_in_n_v = {r_busy_in_n, l_busy_in_n};
  assign addr_v[0]  = l_addr;
  assign addr_v[1]  = r_addr;
  assign be_v[0]    = l_be;
  assign be_v[1]    = r_be;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dpb_port_track #(.ADDR_W(ADDR_W)) u_trk (
      .clk(clk), .rst(rst), .ce0_n(ce0_n_v[s]), .ce1(ce1_v[s]),
      .addr(addr_v[s]), .sel(sel_v[s]), .held(held_v[s])
    );
    assign block_v[s] = master ? busy_int_v[s] : !bsy_in_n_v[s];
    dpb_write_gate #(.BYTES(BYTES)) u_gate (
      .clk(clk), .rst(rst), .sel(sel_v[s]), .we(we_v[s]), .be(be_v[s]),
      .block(block_v[s]), .wr(wr_v[s]), .blocked(blocked_v[s])
    );
  end

  dpb_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst(rst), .sel_l(sel_v[0]), .sel_r(sel_v[1]),
    .addr_l(addr_v[0]), .addr_r(addr_v[1]),
    .held_l(held_v[0]), .held_r(held_v[1]), .hit(hit), .loser(loser)
  );

  assign busy_int_v[0] = !rst && hit && (loser == LOSE_LEFT);
  assign busy_int_v[1] = !rst && hit && (loser == LOSE_RIGHT);

  assign l_busy_out_n = !(master && busy_int_v[0]);
  assign r_busy_out_n = !(master && busy_int_v[1]);
  assign l_wr         = wr_v[0];
  assign r_wr         = wr_v[1];

  assign l_sel     = sel_v[0];
  assign r_sel     = sel_v[1];
  assign l_blocked = blocked_v[0];
  assign r_blocked = blocked_v[1];
endmodule

// File: rtl/dp_busy_arb_chk.sv
module dp_busy_arb_chk #(
  parameter int ADDR_W = 15,
  parameter int BYTES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              master,
  input logic              l_we,
  input logic              r_we,
  input logic [ADDR_W-1:0] l_addr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_ce0_n,
  input logic              l_ce1,
  input logic              r_ce0_n,
  input logic              r_ce1,
  input logic              l_busy_in_n,
  input logic              r_busy_in_n,
  input logic              l_busy_out_n,
  input logic              r_busy_out_n,
  input logic [BYTES-1:0]  l_wr,
  input logic [BYTES-1:0]  r_wr,
  input logic              hit,
  input logic              l_sel,
  input logic              r_sel,
  input logic              l_blocked,
  input logic              r_blocked
);
  p_never_both_busy_r5: assert property (@(posedge clk) disable iff (rst)
    !(!l_busy_out_n && !r_busy_out_n));

  p_busy_needs_match_r2: assert property (@(posedge clk) disable iff (rst)
    (!l_busy_out_n || !r_busy_out_n) |->
      (!l_ce0_n && l_ce1 && !r_ce0_n && r_ce1 && l_addr == r_addr));

  p_hit_one_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (master && hit) |-> ($countones({l_busy_out_n, r_busy_out_n}) == 1));

  p_earlier_left_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (master && hit && $past(l_sel) && $past(l_addr) == l_addr &&
     !($past(r_sel) && $past(r_addr) == r_addr)) |-> !r_busy_out_n);

  p_busy_gates_left_r6: assert property (@(posedge clk) disable iff (rst)
    (master && !l_busy_out_n) |-> (l_wr == '0));

  p_busy_gates_right_r6: assert property (@(posedge clk) disable iff (rst)
    (master && !r_busy_out_n) |-> (r_wr == '0));

  p_slave_outputs_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !master |-> (l_busy_out_n && r_busy_out_n));

  p_slave_inhibit_left_r7: assert property (@(posedge clk) disable iff (rst)
    (!master && !l_busy_in_n) |-> (l_wr == '0));

  p_slave_inhibit_right_r7: assert property (@(posedge clk) disable iff (rst)
    (!master && !r_busy_in_n) |-> (r_wr == '0));

  p_restrobe_left_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(l_blocked) && l_we) |-> (l_wr == '0));

  p_restrobe_right_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(r_blocked) && r_we) |-> (r_wr == '0));
endmodule

bind dp_busy_arb dp_busy_arb_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
  .clk(clk), .rst(rst), .master(master), .l_we(l_we), .r_we(r_we),
  .l_addr(l_addr), .r_addr(r_addr), .l_ce0_n(l_ce0_n), .l_ce1(l_ce1),
  .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .l_busy_in_n(l_busy_in_n),
  .r_busy_in_n(r_busy_in_n), .l_busy_out_n(l_busy_out_n),
  .r_busy_out_n(r_busy_out_n), .l_wr(l_wr), .r_wr(r_wr), .hit(hit),
  .l_sel(l_sel), .r_sel(r_sel), .l_blocked(l_blocked), .r_blocked(r_blocked)
);

// File: tb/sim_dp_busy_arb.sv
module sim_dp_busy_arb;
  localparam int AW = 15;
  localparam int NB = 2;
  localparam int NVEC = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master = 1'b1;
  logic l_ce0_n = 1'b1, l_ce1 = 1'b0, l_we = 1'b0;
  logic r_ce0_n = 1'b1, r_ce1 = 1'b0, r_we = 1'b0;
  logic [NB-1:0] l_be = '0, r_be = '0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic l_busy_out_n, r_busy_out_n;
  logic [NB-1:0] l_wr, r_wr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  dp_busy_arb #(.ADDR_W(AW), .BYTES(NB)) u0 (
    .clk(clk), .rst(rst), .master(master),
    .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_we(l_we), .l_be(l_be), .l_addr(l_addr),
    .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_we(r_we), .r_be(r_be), .r_addr(r_addr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n),
    .l_wr(l_wr), .r_wr(r_wr)
  );

  typedef struct packed {
    logic          m;
    logic          lc0, lc1, lwe;
    logic [NB-1:0] lbe;
    logic [AW-1:0] la;
    logic          rc0, rc1, rwe;
    logic [NB-1:0] rbe;
    logic [AW-1:0] ra;
    logic          bil, bir;
    logic          ebl, ebr;
    logic [NB-1:0] ewl, ewr;
    logic [3:0]    req;
  } vec_t;

  function automatic vec_t mk(logic m, logic lc0, logic lc1, logic lwe, logic [NB-1:0] lbe,
                              logic [AW-1:0] la, logic rc0, logic rc1, logic rwe,
                              logic [NB-1:0] rbe, logic [AW-1:0] ra, logic bil, logic bir,
                              logic ebl, logic ebr, logic [NB-1:0] ewl, logic [NB-1:0] ewr,
                              logic [3:0] req);
    vec_t v;
    v = '{m, lc0, lc1, lwe, lbe, la, rc0, rc1, rwe, rbe, ra, bil, bir, ebl, ebr, ewl, ewr, req};
    return v;
  endfunction

  // Rows run back to back; each one depends on the history left by the rows above it.
  localparam vec_t TBL [NVEC] = '{
    mk(1, 1,1,0,2'b00,15'd5, 1,1,0,2'b00,15'd5, 1,1, 1,1, 2'b00,2'b00, 4'd1),  // R1 both off
    mk(1, 0,1,0,2'b00,15'd5, 0,0,0,2'b00,15'd5, 1,1, 1,1, 2'b00,2'b00, 4'd1),  // R1 ce1 low deselects
    mk(1, 0,1,0,2'b00,15'd5, 0,1,0,2'b00,15'd5, 1,1, 1,0, 2'b00,2'b00, 4'd4),  // R4 left earlier
    mk(1, 0,1,0,2'b00,15'd5, 0,1,1,2'b11,15'd5, 1,1, 1,0, 2'b00,2'b00, 4'd6),  // R6 loser write gated
    mk(1, 0,1,1,2'b01,15'd5, 0,1,1,2'b11,15'd5, 1,1, 1,0, 2'b01,2'b00, 4'd11), // R11 low byte only
    mk(1, 1,1,0,2'b00,15'd5, 0,1,1,2'b11,15'd5, 1,1, 1,1, 2'b00,2'b00, 4'd9),  // R9 still held off
    mk(1, 1,1,0,2'b00,15'd5, 0,1,0,2'b11,15'd5, 1,1, 1,1, 2'b00,2'b00, 4'd9),  // R9 strobe dropped
    mk(1, 1,1,0,2'b00,15'd5, 0,1,1,2'b10,15'd5, 1,1, 1,1, 2'b00,2'b10, 4'd9),  // R9 new strobe writes
    mk(1, 0,1,0,2'b00,15'd5, 0,1,1,2'b11,15'd5, 1,1, 0,1, 2'b00,2'b11, 4'd3),  // R3 writer right still wins
    mk(1, 0,1,1,2'b11,15'd9, 0,1,0,2'b00,15'd9, 1,1, 1,0, 2'b11,2'b00, 4'd5),  // R5 tie -> right busy
    mk(1, 0,1,1,2'b11,15'd9, 0,1,1,2'b11,15'd10,1,1, 1,1, 2'b11,2'b11, 4'd2),  // R2 differing addresses
    mk(1, 0,1,1,2'b11,15'd9, 0,1,1,2'b11,15'd9, 1,1, 1,0, 2'b11,2'b00, 4'd4),  // R4 right arrives late
    mk(1, 0,1,1,2'b11,15'd9, 0,1,1,2'b11,15'd10,1,1, 1,1, 2'b11,2'b00, 4'd8),  // R8 released, R9 held
    mk(0, 0,1,1,2'b11,15'd3, 0,1,0,2'b00,15'd3, 1,1, 1,1, 2'b11,2'b00, 4'd7),  // R7 slave, no busy out
    mk(0, 0,1,1,2'b11,15'd3, 0,1,1,2'b11,15'd3, 0,1, 1,1, 2'b00,2'b11, 4'd7),  // R7 input low inhibits
    mk(0, 0,1,1,2'b11,15'd3, 0,1,1,2'b11,15'd3, 1,1, 1,1, 2'b00,2'b11, 4'd9),  // R9 slave held off
    mk(1, 0,1,0,2'b00,15'd3, 0,1,1,2'b11,15'd3, 1,0, 1,0, 2'b00,2'b00, 4'd6),  // R6 master, right loses
    mk(1, 0,1,1,2'b11,15'd3, 0,1,0,2'b00,15'd3, 0,1, 1,0, 2'b11,2'b00, 4'd6)   // R6 busy input ignored
  };

  task automatic check(input string req, input logic ebl, input logic ebr,
                       input logic [NB-1:0] ewl, input logic [NB-1:0] ewr);
    checks++;
    if (l_busy_out_n !== ebl || r_busy_out_n !== ebr || l_wr !== ewl || r_wr !== ewr) begin
      fails++;
      $display("FAIL %s: busy l/r=%b/%b wr l/r=%b/%b, expected busy %b/%b wr %b/%b",
               req, l_busy_out_n, r_busy_out_n, l_wr, r_wr, ebl, ebr, ewl, ewr);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog: run incomplete, expected finish");
    finish_run();
  end

  initial begin
    // R10: during reset, matching selected writers see no busy and no writes.
    repeat (2) @(negedge clk);
    l_ce0_n = 0; l_ce1 = 1; l_we = 1; l_be = 2'b11; l_addr = 15'd7;
    r_ce0_n = 0; r_ce1 = 1; r_we = 1; r_be = 2'b11; r_addr = 15'd7;
    #1 check("R10 in reset", 1'b1, 1'b1, 2'b00, 2'b00);
    @(negedge clk);
    #1 check("R10 held reset", 1'b1, 1'b1, 2'b00, 2'b00);
    @(negedge clk);
    rst = 0;
    // R10: first cycle out of reset is a same-cycle arrival, right loses (R5 tie rule).
    #1 check("R10 first cycle tie", 1'b1, 1'b0, 2'b11, 2'b00);
    @(negedge clk);
    // Upper address corner: full-width comparison, differing top bit means no match (R2).
    l_we = 0; r_we = 0; l_addr = 15'h7FFF; r_addr = 15'h3FFF;
    #1 check("R2 top bit differs", 1'b1, 1'b1, 2'b00, 2'b00);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      master = TBL[i].m;
      l_ce0_n = TBL[i].lc0; l_ce1 = TBL[i].lc1; l_we = TBL[i].lwe;
      l_be = TBL[i].lbe; l_addr = TBL[i].la;
      r_ce0_n = TBL[i].rc0; r_ce1 = TBL[i].rc1; r_we = TBL[i].rwe;
      r_be = TBL[i].rbe; r_addr = TBL[i].ra;
      l_busy_in_n = TBL[i].bil; r_busy_in_n = TBL[i].bir;
      #1 check($sformatf("R%0d row %0d", TBL[i].req, i),
               TBL[i].ebl, TBL[i].ebr, TBL[i].ewl, TBL[i].ewr);
    end

    // R8: holding the match keeps left busy; ending it releases in that cycle.
    @(negedge clk);
    master = 1; l_busy_in_n = 1; r_busy_in_n = 1;
    l_ce0_n = 0; l_ce1 = 1; l_we = 0; l_addr = 15'd20;
    r_ce0_n = 1; r_ce1 = 1; r_we = 0; r_addr = 15'd20;
    #1 check("R8 setup", 1'b1, 1'b1, 2'b00, 2'b00);
    @(negedge clk);
    l_ce0_n = 1; r_ce0_n = 0;
    #1 check("R8 right alone", 1'b1, 1'b1, 2'b00, 2'b00);
    @(negedge clk);
    l_ce0_n = 0;
    #1 check("R4 left late", 1'b0, 1'b1, 2'b00, 2'b00);
    @(negedge clk);
    #1 check("R4 loser persists", 1'b0, 1'b1, 2'b00, 2'b00);
    @(negedge clk);
    r_ce1 = 0;
    #1 check("R8 release on deselect", 1'b1, 1'b1, 2'b00, 2'b00);

    @(negedge clk);
    finish_run();
  end
endmodule